// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block holds one watchdog timer for each processor core. Software programs each timer through a small write port. A write carries a 16-bit reload length and a 2-bit mode and selects the target core by index. The length becomes the upper 16 bits of a 24-bit down-counter, and the low 8 bits load as zero. The counter steps down once every `DIV` clock cycles. A per-core poke strobe restarts the count. The current count of any one core can be read through a selectable read port.

An expiry period is one full run of the counter down to zero without a poke. Each unserviced period moves the core's stage sequencer one step further. The first period raises the interrupt output. The second raises the non-maskable interrupt output. The third raises the soft-reset request. The mode sets how far the sequence may go, and mode 0 stops the timer. Each stage output stays high until that core is poked or its control is rewritten.

Top module: `stage_watchdog`

## Requirements
- R1: After reset, every core's interrupt, NMI and soft-reset outputs are 0, and the count read for every core is 0.
- R2: A control write to core c loads that core's count with {length, 8'h00}. The new count is readable on `rdCount`, with `rdCore` = c, from the cycle after the write edge.
- R3: When the mode is nonzero, the count drops by exactly one every `DIV` clock cycles after a reload. After k clock edges past the reload edge it reads length*256 - floor(k/DIV), until it reaches 0.
- R4: The period P is (length*256 + 1) * `DIV` clock cycles. It is measured from the reload edge to the edge at which the counter, already at 0, takes one more step and reloads. When the mode is 1, 2 or 3, the interrupt output rises exactly P edges after the reload edge.
- R5: When the mode is 2 or 3, the NMI output rises exactly 2P edges after the reload edge.
- R6: When the mode is 3, the soft-reset output rises exactly 3P edges after the reload edge. The interrupt and NMI outputs stay high while it is high.
- R7: Escalation stops at the stage the mode allows. Mode 1 stops at the interrupt stage, mode 2 at the NMI stage and mode 3 at soft reset. Later periods neither raise a further output nor drop one that is already raised.
- R8: In mode 0 the count stays at {length, 8'h00} and no stage output is ever raised.
- R9: A poke of core c reloads its count with {length, 8'h00} and drops all three of its stage outputs on the next edge. Timing then restarts from that edge.
- R10: A poke or control write aimed at one core leaves every other core's count and stage outputs unchanged.
- R11: A control write clears that core's raised stage outputs on the same edge at which it loads the new count and mode.
- R12: A length of 0 gives a period of `DIV` clock cycles. The interrupt rises `DIV` edges after the reload edge when the mode is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Control write strobe |
| cfgCore | input | CORE_W | Core index the control write targets |
| cfgLen | input | LEN_W | Reload length (upper bits of the counter) |
| cfgMode | input | 2 | 0 off, 1 interrupt only, 2 up to NMI, 3 up to soft reset |
| poke | input | NUM_CORES | Per-core restart strobe |
| rdCore | input | CORE_W | Core whose count is shown on rdCount |
| rdCount | output | LEN_W+LOW_W | Current count of the selected core |
| irqOut | output | NUM_CORES | Per-core interrupt stage |
| nmiOut | output | NUM_CORES | Per-core NMI stage |
| softRstOut | output | NUM_CORES | Per-core soft-reset request |

## Verification
The bench runs every mode against lengths 0, 1 and 2. At each stage it samples the outputs one edge before and exactly at the computed boundaries P, 2P and 3P. This separates an off-by-one in the prescaler or the counter from a wrong stage cap. A further sample at 4P shows whether each mode really stops escalating. A mid-period count sample checks the decrement rate on its own, independent of the expiry logic. Two cross-core patterns check isolation between cores: one core is poked continuously while its neighbour is left to escalate, and a rewrite of the control is issued on a fully escalated core.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_IRQ  = 2'd1,
    STG_NMI  = 2'd2,
    STG_RST  = 2'd3
  } stage_t;

  typedef struct packed {
    logic takeCfg;
    logic reload;
    logic run;
  } dpCtrl_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  parameter int DIV   = 256,
  localparam int CNT_W = LEN_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtrl_t          ctrl,
  input  logic [LEN_W-1:0] cfgLen,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] pre;
  logic [LEN_W-1:0] lenReg;
  logic             tick;
  logic [LEN_W-1:0] loadLen;

  assign tick    = ctrl.run && (pre == PRE_W'(DIV - 1));
  assign expire  = tick && (count == '0);
  assign loadLen = ctrl.takeCfg ? cfgLen : lenReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      count  <= '0;
      lenReg <= '0;
    end else if (ctrl.reload) begin
      pre   <= '0;
      count <= {loadLen, {LOW_W{1'b0}}};
      if (ctrl.takeCfg) lenReg <= cfgLen;
    end else if (ctrl.run) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) count <= (count == '0) ? {lenReg, {LOW_W{1'b0}}} : count - 1'b1;
    end
  end

  // R9: a plain reload restores the stored length into the top bits
  p_reload_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.reload && !ctrl.takeCfg) |=> (count == {$past(lenReg), {LOW_W{1'b0}}}));

  // R8: a stopped counter does not move
  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.reload) |=> $stable(count));

  // R3: a running counter steps by at most one
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.reload && count != '0) |=>
      (count == $past(count) || count == $past(count) - 1'b1));
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgHit,
  input  logic [1:0] cfgMode,
  input  logic       poke,
  input  logic       expire,
  output dpCtrl_t    ctrl,
  output logic       irq,
  output logic       nmi,
  output logic       softRst
);
  logic [1:0] modeReg;
  stage_t     stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg <= 2'd0;
      stage   <= STG_IDLE;
    end else if (cfgHit) begin
      modeReg <= cfgMode;
      stage   <= STG_IDLE;
    end else if (poke) begin
      stage <= STG_IDLE;
    end else if (expire && (2'(stage) < modeReg)) begin
      stage <= stage_t'(2'(stage) + 2'd1);
    end
  end

  assign ctrl.takeCfg = cfgHit;
  assign ctrl.reload  = cfgHit || poke;
  assign ctrl.run     = (modeReg != 2'd0);

  assign irq     = (stage != STG_IDLE);
  assign nmi     = (stage == STG_NMI) || (stage == STG_RST);
  assign softRst = (stage == STG_RST);

  // R7: the stage never goes past the mode cap
  p_stage_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    2'(stage) <= modeReg);

  // R6: soft reset is only seen with both earlier stages raised
  p_rst_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |-> (nmi && irq));

  // R9: a poke drops every stage on the next edge
  p_clear_on_poke_r9: assert property (@(posedge clk) disable iff (!rst_n)
    poke |=> (!irq && !nmi && !softRst));

  // R4: stages change only on expiry, poke or control write
  p_stage_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !poke && !cfgHit) |=> $stable(stage));
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import wdog_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LEN_W     = 16,
  parameter int LOW_W     = 8,
  parameter int DIV       = 256,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int CNT_W    = LEN_W + LOW_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWe,
  input  logic [CORE_W-1:0]    cfgCore,
  input  logic [LEN_W-1:0]     cfgLen,
  input  logic [1:0]           cfgMode,
  input  logic [NUM_CORES-1:0] poke,
  input  logic [CORE_W-1:0]    rdCore,
  output logic [CNT_W-1:0]     rdCount,
  output logic [NUM_CORES-1:0] irqOut,
  output logic [NUM_CORES-1:0] nmiOut,
  output logic [NUM_CORES-1:0] softRstOut
);
  logic [CNT_W-1:0] coreCount [NUM_CORES];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    dpCtrl_t ctrl;
    logic    expire;
    logic    cfgHit;

    assign cfgHit = cfgWe && (cfgCore == CORE_W'(g));

    wdog_ctl i_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfgHit  (cfgHit),
      .cfgMode (cfgMode),
      .poke    (poke[g]),
      .expire  (expire),
      .ctrl    (ctrl),
      .irq     (irqOut[g]),
      .nmi     (nmiOut[g]),
      .softRst (softRstOut[g])
    );

    wdog_dp #(.LEN_W(LEN_W), .LOW_W(LOW_W), .DIV(DIV)) i_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (ctrl),
      .cfgLen (cfgLen),
      .count  (coreCount[g]),
      .expire (expire)
    );
  end

  always_comb begin
    rdCount = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (rdCore == CORE_W'(i)) rdCount = coreCount[i];
  end
endmodule

// File: tb/test_stage_watchdog.sv
`timescale 1ns/1ps
module test_stage_watchdog;
  localparam int NC  = 2;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [0:0]  cfgCore = '0;
  logic [15:0] cfgLen = '0;
  logic [1:0]  cfgMode = '0;
  logic [1:0]  poke = '0;
  logic [0:0]  rdCore = '0;
  logic [23:0] rdCount;
  logic [1:0]  irqOut, nmiOut, softRstOut;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int e0 = 0;

  stage_watchdog #(.NUM_CORES(NC), .LEN_W(16), .LOW_W(8), .DIV(DIV)) i_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgCore(cfgCore), .cfgLen(cfgLen),
    .cfgMode(cfgMode), .poke(poke), .rdCore(rdCore), .rdCount(rdCount),
    .irqOut(irqOut), .nmiOut(nmiOut), .softRstOut(softRstOut)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int core, input int len, input int mode);
    @(negedge clk);
    cfgWe = 1'b1; cfgCore = 1'(core); cfgLen = 16'(len); cfgMode = 2'(mode);
    @(negedge clk);
    cfgWe = 1'b0;
    e0 = cyc;
  endtask

  task automatic pokeCore(input int core);
    @(negedge clk);
    poke[core] = 1'b1;
    @(negedge clk);
    poke = '0;
    e0 = cyc;
  endtask

  task automatic waitTo(input int t);
    while (cyc - e0 < t) @(negedge clk);
  endtask

  initial begin
    #750000;
    mismatched++;
    compared++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      rdCore = 1'(c);
      #0.1;
      check("R1 count", int'(rdCount), 0);
      check("R1 irq", int'(irqOut[c]), 0);
      check("R1 nmi", int'(nmiOut[c]), 0);
      check("R1 rst", int'(softRstOut[c]), 0);
    end
    rdCore = '0;

    for (int len = 0; len < 3; len++) begin
      for (int mode = 0; mode < 4; mode++) begin
        int p;
        int base;
        p = (len * 256 + 1) * DIV;
        base = len * 256;
        cfgWrite(0, len, mode);
        check("R2 load", int'(rdCount), base);
        check("R11 irq cleared", int'(irqOut[0]), 0);
        if (mode != 0 && len != 0) begin
          waitTo(5 * DIV + 2);
          check("R3 rate", int'(rdCount), base - 5);
        end
        waitTo(p - 1);
        check("R4 irq early", int'(irqOut[0]), 0);
        if (mode == 0) check("R8 hold", int'(rdCount), base);
        else check("R3 at zero", int'(rdCount), 0);
        waitTo(p);
        check("R4 irq", int'(irqOut[0]), (mode >= 1) ? 1 : 0);
        if (len == 0) check("R12 len0 period", int'(irqOut[0]), (mode >= 1) ? 1 : 0);
        check("R8 no nmi yet", int'(nmiOut[0]), 0);
        waitTo(2 * p - 1);
        check("R5 nmi early", int'(nmiOut[0]), 0);
        waitTo(2 * p);
        check("R5 nmi", int'(nmiOut[0]), (mode >= 2) ? 1 : 0);
        waitTo(3 * p - 1);
        check("R6 rst early", int'(softRstOut[0]), 0);
        waitTo(3 * p);
        check("R6 rst", int'(softRstOut[0]), (mode == 3) ? 1 : 0);
        check("R6 irq held", int'(irqOut[0]), (mode >= 1) ? 1 : 0);
        waitTo(4 * p + 1);
        check("R7 irq cap", int'(irqOut[0]), (mode >= 1) ? 1 : 0);
        check("R7 nmi cap", int'(nmiOut[0]), (mode >= 2) ? 1 : 0);
        check("R7 rst cap", int'(softRstOut[0]), (mode == 3) ? 1 : 0);
        if (mode == 0) check("R8 count held", int'(rdCount), base);
        check("R10 other core quiet", int'(irqOut[1]), 0);
        pokeCore(0);
        check("R9 irq", int'(irqOut[0]), 0);
        check("R9 nmi", int'(nmiOut[0]), 0);
        check("R9 rst", int'(softRstOut[0]), 0);
        check("R9 count", int'(rdCount), base);
        if (mode != 0) begin
          waitTo(p);
          check("R9 restart irq", int'(irqOut[0]), 1);
        end
      end
    end

    // R11: control write clears a fully escalated core
    cfgWrite(0, 0, 3);
    waitTo(3 * DIV);
    check("R11 escalated", int'(softRstOut[0]), 1);
    cfgWrite(0, 1, 2);
    check("R11 rst cleared", int'(softRstOut[0]), 0);
    check("R11 nmi cleared", int'(nmiOut[0]), 0);
    check("R11 count", int'(rdCount), 256);

    // R10: core 1 escalates while core 0 is poked continuously
    cfgWrite(1, 0, 3);
    cfgWrite(0, 1, 3);
    @(negedge clk);
    poke[0] = 1'b1;
    repeat (30) @(negedge clk);
    check("R10 core1 rst", int'(softRstOut[1]), 1);
    check("R10 core0 irq", int'(irqOut[0]), 0);
    rdCore = 1'b0;
    #0.1;
    check("R10 core0 count", int'(rdCount), 256);
    poke = '0;
    rdCore = 1'b1;
    #0.1;
    check("R10 core1 count", int'(rdCount), 0);
    pokeCore(1);
    check("R10 core1 cleared", int'(softRstOut[1]), 0);
    check("R10 core0 untouched", int'(irqOut[0]), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule